// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Group

This block is the boundary-scan slice for a single bidirectional digital pad. It sits between the chip's port logic and the pad. It lets a test controller observe what the pad sees and, in test mode, take over what the pad drives. The pad's three directions of information are output enable, output value and input value. They travel through a scan segment of only two flops: a control stage and a data stage. The data stage does two jobs. It receives the pad's input value when capturing. It supplies the driven value when updating. A third, ordinary scan cell ahead of the pair carries the pad's pull-up enable.

In normal operation the port's direction and data bits reach the pad unchanged. The pull-up is switched on only for an input pin whose port bit is set while pull-ups are globally allowed. With the test-mode select raised, the update holders of the three cells drive the pad instead. Shift, capture and update strobes come from a test access port controller outside this block, synchronous to the scan clock.

Top module: `pin_scan_group`

## Requirements
- R1: While reset is low, every scan stage and every update holder reads 0, so `tdo` is 0. With `test_mode`=1, `pad_oe`, `pad_out` and `pad_pu` are then all 0.
- R2: With `test_mode`=0, `pad_oe` equals `func_dir` and `pad_out` equals `func_port`, without any clock edge.
- R3: With `test_mode`=0, `pad_pu` is 1 exactly when `pullup_dis`=0, `func_dir`=0 and `func_port`=1.
- R4: A clock edge with `capture_en`=1 and `shift_en`=0 loads three values. The pull-up cell takes the functional pull-up value of R3. The control stage takes the `pad_oe` value present at that edge. The data stage takes the raw `pad_in` value at that edge, with no synchronizing delay.
- R5: A clock edge with `shift_en`=1 moves the chain one place. The order is `tdi` into the pull-up cell, pull-up cell into the control stage, control stage into the data stage. `tdo` always shows the data stage, so a bit entering at `tdi` appears at `tdo` after the third shift edge.
- R6: When `shift_en` and `capture_en` are both 1 at an edge, the shift takes place and the capture is ignored.
- R7: A clock edge with `update_en`=1 copies the pull-up, control and data stages into their holders. With `test_mode`=1, those holders drive `pad_pu`, `pad_oe` and `pad_out` respectively.
- R8: Without `update_en`, the holders keep their values, so in test mode the pad outputs stay steady while the chain shifts or captures.
- R9: An edge with neither `shift_en` nor `capture_en` leaves every scan stage, and so `tdo`, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the source |
| test_mode | input | 1 | 1 hands the pad to the update holders |
| shift_en | input | 1 | Shift strobe for the chain |
| capture_en | input | 1 | Capture strobe for the chain |
| update_en | input | 1 | Update strobe for the holders |
| tdi | input | 1 | Serial data into the group |
| tdo | output | 1 | Serial data out of the group (data stage) |
| func_dir | input | 1 | Functional direction bit, 1 = output |
| func_port | input | 1 | Functional port data bit |
| pullup_dis | input | 1 | Global pull-up disable |
| pad_in | input | 1 | Raw value seen at the pad |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output value |
| pad_pu | output | 1 | Pad pull-up enable |

## Verification
The assertions assume that the strobes, `tdi` and the functional inputs come from logic clocked by the same scan clock. They also assume that `pad_in` has settled before each rising edge, because the data stage samples it with no synchronizer. Under those assumptions, a value sampled at an edge is the value the cell loads. The stimulus changes every input one nanosecond after a falling edge, so each input is steady across the rising edge that consumes it.

// File: rtl/pin_scan_pkg.sv
package pin_scan_pkg;
  // Stages in the compacted bidirectional segment: control, then data.
  localparam int unsigned SEG_STAGES = 2;
  localparam int unsigned SEG_CTRL   = 0;
  localparam int unsigned SEG_DATA   = SEG_STAGES - 1;
  // Cells in the whole group: pull-up cell plus the segment.
  localparam int unsigned GROUP_CELLS = SEG_STAGES + 1;

  // Functional pull-up: allowed globally, pin is an input, port bit set.
  function automatic logic pullup_enable(input logic dis, input logic dir,
                                         input logic port);
    return !dis && !dir && port;
  endfunction
endpackage

// File: rtl/pin_scan_cell.sv
module pin_scan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic capture_en,
  input  logic update_en,
  input  logic ser_in,
  input  logic cap_in,
  output logic ser_out,
  output logic upd_out
);
  logic stage_q, stage_d;
  logic hold_q, hold_d;

  // Next state: shift wins over capture.
  always_comb begin
    stage_d = stage_q;
    if (shift_en) begin
      stage_d = ser_in;
    end else if (capture_en) begin
      stage_d = cap_in;
    end
  end

  always_comb begin
    hold_d = hold_q;
    if (update_en) begin
      hold_d = stage_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      hold_q  <= hold_d;
    end
  end

  assign ser_out = stage_q;
  assign upd_out = hold_q;

  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (ser_out == $past(ser_in)));
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && !shift_en) |=> (ser_out == $past(cap_in)));
  p_shift_over_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && shift_en) |=> (ser_out == $past(ser_in)));
  p_stage_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_en && !shift_en) |=> $stable(ser_out));
  p_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    update_en |=> (upd_out == $past(ser_out)));
  p_holder_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(upd_out));
endmodule

// File: rtl/pin_scan_bidir_seg.sv
module pin_scan_bidir_seg
  import pin_scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic capture_en,
  input  logic update_en,
  input  logic ser_in,
  input  logic cap_oe,
  input  logic cap_pad,
  output logic ser_out,
  output logic upd_oe,
  output logic upd_dat
);
  logic [SEG_STAGES:0]   chain;
  logic [SEG_STAGES-1:0] cap_v;
  logic [SEG_STAGES-1:0] hold_v;

  assign chain[0]        = ser_in;
  assign cap_v[SEG_CTRL] = cap_oe;
  assign cap_v[SEG_DATA] = cap_pad;

  for (genvar g = 0; g < SEG_STAGES; g++) begin : g_stage
    pin_scan_cell cell_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_en   (shift_en),
      .capture_en (capture_en),
      .update_en  (update_en),
      .ser_in     (chain[g]),
      .cap_in     (cap_v[g]),
      .ser_out    (chain[g+1]),
      .upd_out    (hold_v[g])
    );
  end

  assign ser_out = chain[SEG_STAGES];
  assign upd_oe  = hold_v[SEG_CTRL];
  assign upd_dat = hold_v[SEG_DATA];

  // Data stage follows the control stage one shift later.
  p_seg_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (ser_out == $past(chain[SEG_CTRL+1])));
  p_seg_raw_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && !shift_en) |=> (ser_out == $past(cap_pad)));
endmodule

// File: rtl/pin_scan_pad_mux.sv
module pin_scan_pad_mux
  import pin_scan_pkg::*;
(
  input  logic test_mode,
  input  logic func_dir,
  input  logic func_port,
  input  logic pullup_dis,
  input  logic upd_pu,
  input  logic upd_oe,
  input  logic upd_dat,
  output logic func_pu,
  output logic pad_oe,
  output logic pad_out,
  output logic pad_pu
);
  always_comb begin
    func_pu = pullup_enable(pullup_dis, func_dir, func_port);
    if (test_mode) begin
      pad_oe  = upd_oe;
      pad_out = upd_dat;
      pad_pu  = upd_pu;
    end else begin
      pad_oe  = func_dir;
      pad_out = func_port;
      pad_pu  = func_pu;
    end
  end
endmodule

// File: rtl/pin_scan_group.sv
module pin_scan_group
  import pin_scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic test_mode,
  input  logic shift_en,
  input  logic capture_en,
  input  logic update_en,
  input  logic tdi,
  output logic tdo,
  input  logic func_dir,
  input  logic func_port,
  input  logic pullup_dis,
  input  logic pad_in,
  output logic pad_oe,
  output logic pad_out,
  output logic pad_pu
);
  logic func_pu;
  logic pu_ser;
  logic upd_pu, upd_oe, upd_dat;

  // TDI side: pull-up cell.
  pin_scan_cell pu_cell_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .capture_en (capture_en),
    .update_en  (update_en),
    .ser_in     (tdi),
    .cap_in     (func_pu),
    .ser_out    (pu_ser),
    .upd_out    (upd_pu)
  );

  // TDO side: control stage then data stage.
  pin_scan_bidir_seg seg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .capture_en (capture_en),
    .update_en  (update_en),
    .ser_in     (pu_ser),
    .cap_oe     (pad_oe),
    .cap_pad    (pad_in),
    .ser_out    (tdo),
    .upd_oe     (upd_oe),
    .upd_dat    (upd_dat)
  );

  pin_scan_pad_mux mux_i (
    .test_mode  (test_mode),
    .func_dir   (func_dir),
    .func_port  (func_port),
    .pullup_dis (pullup_dis),
    .upd_pu     (upd_pu),
    .upd_oe     (upd_oe),
    .upd_dat    (upd_dat),
    .func_pu    (func_pu),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_pu     (pad_pu)
  );

  // A bit shifted in reaches tdo after GROUP_CELLS shift edges.
  p_chain_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && $past(shift_en) && $past(shift_en, 2))
      |=> (tdo == $past(tdi, GROUP_CELLS)));
  p_test_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && $past(test_mode) && !$past(update_en))
      |-> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));
endmodule

// File: tb/pin_scan_group_tb_top.sv
module pin_scan_group_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
  logic tdi = 1'b0, func_dir = 1'b0, func_port = 1'b0, pullup_dis = 1'b0, pad_in = 1'b0;
  logic tdo, pad_oe, pad_out, pad_pu;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic  oe, dout, pu, so;
    string req;
  } exp_t;
  exp_t sb_q[$];

  // Reference state kept from the requirements.
  logic m_pu = 1'b0, m_ctl = 1'b0, m_dat = 1'b0;
  logic h_pu = 1'b0, h_oe = 1'b0, h_dat = 1'b0;

  always #5 clk = ~clk;

  pin_scan_group dut_i (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .tdi(tdi), .tdo(tdo),
    .func_dir(func_dir), .func_port(func_port), .pullup_dis(pullup_dis),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {oe,out,pu,tdo} actual %b expected %b", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes what must be seen after the edge.
  task automatic step(input logic cap, input logic sh, input logic upd, input logic tm,
                      input logic dir, input logic port, input logic dis, input logic pin,
                      input logic din, input string req);
    exp_t e;
    logic fpu, cur_oe, n_pu, n_ctl, n_dat;
    @(negedge clk);
    #1;
    capture_en = cap; shift_en = sh; update_en = upd; test_mode = tm;
    func_dir = dir; func_port = port; pullup_dis = dis; pad_in = pin; tdi = din;
    fpu    = !dis && !dir && port;              // R3
    cur_oe = tm ? h_oe : dir;                   // pad_oe at the edge
    n_pu = m_pu; n_ctl = m_ctl; n_dat = m_dat;
    if (sh) begin n_pu = din; n_ctl = m_pu; n_dat = m_ctl; end       // R5, R6
    else if (cap) begin n_pu = fpu; n_ctl = cur_oe; n_dat = pin; end // R4
    if (upd) begin h_pu = m_pu; h_oe = m_ctl; h_dat = m_dat; end     // R7
    m_pu = n_pu; m_ctl = n_ctl; m_dat = n_dat;
    e.oe   = tm ? h_oe  : dir;
    e.dout = tm ? h_dat : port;
    e.pu   = tm ? h_pu  : fpu;
    e.so   = m_dat;
    e.req  = req;
    sb_q.push_back(e);
  endtask

  // Monitor: compares at the falling edge following each driven cycle.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check4(e.req, {pad_oe, pad_out, pad_pu, tdo}, {e.oe, e.dout, e.pu, e.so});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    test_mode = 1'b1; func_dir = 1'b1; func_port = 1'b1; pad_in = 1'b1; tdi = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state with the holders driving the pad
    check4("R1", {pad_oe, pad_out, pad_pu, tdo}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    test_mode = 1'b0;

    // R2, R3: functional pass-through over every dir/port/disable combination
    for (int k = 0; k < 8; k++)
      step(0, 0, 0, 0, k[0], k[1], k[2], 0, 0, k[2:0] == 3'b010 ? "R3" : "R2");

    // R4: capture in functional mode, output pin, pad high
    step(1, 0, 0, 0, 1, 0, 0, 1, 0, "R4");
    // R5: shift it out, with marker bits entering at tdi
    step(0, 1, 0, 0, 1, 0, 0, 0, 1, "R5");
    step(0, 1, 0, 0, 1, 0, 0, 0, 0, "R5");
    step(0, 1, 0, 0, 1, 0, 0, 0, 0, "R5");
    step(0, 1, 0, 0, 1, 0, 0, 0, 0, "R5");
    // R4: capture an input pin with pull-up active and pad low
    step(1, 0, 0, 0, 0, 1, 0, 0, 1, "R4");
    step(0, 1, 0, 0, 0, 1, 0, 1, 0, "R5");
    step(0, 1, 0, 0, 0, 1, 0, 1, 0, "R5");
    // R9: idle edges keep the chain
    step(0, 0, 0, 0, 0, 1, 0, 1, 1, "R9");
    step(0, 0, 0, 0, 0, 1, 0, 0, 1, "R9");

    // R7: load pu=1, oe=1, data=0 then update and take the pad
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 1, 0, 0, 0, 0, 0, 0, 1, "R5");
    step(0, 1, 0, 0, 0, 0, 0, 0, 1, "R5");
    step(0, 0, 1, 1, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 1, 1, 1, 1, 1, 0, "R7");
    // R8: shifting without update leaves the pad alone
    step(0, 1, 0, 1, 0, 1, 0, 1, 0, "R8");
    step(0, 1, 0, 1, 0, 1, 0, 1, 1, "R8");
    step(1, 0, 0, 1, 0, 1, 0, 1, 1, "R8");
    // R4: capture in test mode takes the held output enable
    step(1, 0, 0, 1, 0, 0, 1, 0, 0, "R4");
    // R6: shift and capture together shift
    step(1, 1, 0, 1, 1, 1, 0, 1, 1, "R6");
    step(1, 1, 0, 1, 1, 1, 0, 1, 0, "R6");
    step(1, 1, 0, 1, 1, 1, 0, 1, 0, "R6");
    // R7: second update, then back to functional
    step(0, 0, 1, 1, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R2");

    @(negedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule